// File: doc/BRIEF.md
# Ethernet Host FIFO Word Interface

This block sits between a 32-bit host register port and the byte-wide frame FIFOs of an Ethernet MAC. On the transmit side, the host writes frame body words to a data address. It then writes the final word, which may be partial, to one of four last-word addresses. The two low address bits of that address give the byte count of the final word. The block splits the words into bytes, queues them and tags the final byte as frame end. The MAC drains the queue one byte at a time. When the MAC reports that transmission has finished, the block sets a sticky completion flag and stores the MAC's result code.

On the receive side, the block queues bytes from the MAC and counts the frame length. When the end-of-frame byte arrives, it raises a frame-ready flag. Each host read of the data address returns up to four bytes packed from the top byte lane down. A general status field tells the host how many bytes of the trailing partial word are left. If the receive queue is full, incoming bytes are dropped and an overrun bit is recorded. Turning receive off flushes the queue.

Register map (4-bit address): 0 data, 1 general status / flag clear, 2 transmit status, 3 receive status, 4 control, 8..11 last word with size = address[1:0].

Top module: `eth_word_port`

## Requirements
- R1: After reset, general status (address 1) reads 0x00000001 (only the transmit-empty bit 0 set), control (address 4), transmit status and receive status read 0, and mac_tx_valid is low.
- R2: A write to address 0 queues four bytes in lane order: bits 7:0 first, bits 31:24 last. None of them carries the frame-end mark. General status bit 0 reads 0 while any transmit byte is queued.
- R3: A write to address 8+s queues s bytes from the low lanes, or 4 bytes when s is 0. The last of these bytes is presented with mac_tx_last high.
- R4: The transmit queue holds 64 bytes. A write to address 0 or 8..11 is discarded whole when fewer than 4 bytes are free.
- R5: A mac_tx_done pulse sets general status bit 1 and stores mac_tx_stat in transmit status bits 11:0. Writing 1 to bit 1 of address 1 clears the flag. Writing 0 there leaves it set.
- R6: With receive enabled (control bit 0), a byte with mac_rx_last sets general status bit 2. It also loads receive status bits 31:16 with the frame's byte count, which includes bytes lost to overrun. Writing 1 to bit 2 of address 1 clears the flag.
- R7: A read of address 0 removes up to four receive bytes. The earliest byte appears in bits 31:24 and the next in 23:16, and so on. Lanes with no byte read as zero. General status bit 3 is set while any receive byte is held.
- R8: General status bits 31:28 show the number of held receive bytes when it is 1, 2 or 3, and 0 otherwise.
- R9: A read of address 0 with the receive queue empty returns 0 and leaves the queue empty.
- R10: The receive queue holds 64 bytes. A byte arriving when it is full is dropped and sets receive status bit 0. Clearing control bit 0 empties the queue and clears bit 0. Bytes arriving while receive is disabled are not stored and set no flag.
- R11: While mac_tx_valid is high and mac_tx_ready is low, mac_tx_valid, mac_tx_data and mac_tx_last hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Read data, registered, valid the cycle after reg_rd |
| mac_tx_valid | output | 1 | Transmit byte available |
| mac_tx_data | output | 8 | Transmit byte |
| mac_tx_last | output | 1 | Transmit byte ends the frame |
| mac_tx_ready | input | 1 | MAC takes the transmit byte |
| mac_tx_done | input | 1 | One-cycle pulse: transmission finished |
| mac_tx_stat | input | 12 | Result code (bit 0 ok, 1 deferred, 2 late collision, 3 excess collisions, 4 excess deferral, 5 underrun, 6 oversize, 11:8 collision count) |
| mac_rx_valid | input | 1 | Receive byte present |
| mac_rx_data | input | 8 | Receive byte |
| mac_rx_last | input | 1 | Receive byte ends the frame |

## Verification
The bench targets lane ordering in both directions. A design that reversed the order would send body bytes high lane first, or pack receive bytes into the low lanes, and every byte comparison would fail. It fills the transmit queue past its capacity with the MAC stalled. A design that accepted a partial word, or that wrapped its pointer, would drain other than exactly 64 bytes, or would drain the wrong values. It overflows the receive queue and then toggles the enable, which catches a stale overrun bit or leftover data. It also reads the data port while the queue is empty, which exposes a pointer underflow: that shows up as a nonzero word or as phantom bytes on later reads. Random frame lengths from 1 to 40 cover all four tail sizes in both directions, including size code 0 meaning four bytes.

// File: rtl/ewp_pkg.sv
// Shared constants for the host FIFO word interface: register addresses,
// status bit positions and datapath geometry.
package ewp_pkg;
    localparam int ADDR_W   = 4;
    localparam int LANES    = 4;
    localparam int STAT_W   = 12;
    localparam int LEN_W    = 16;

    localparam logic [ADDR_W-1:0] ADR_DATA   = 4'h0;
    localparam logic [ADDR_W-1:0] ADR_GSTAT  = 4'h1;
    localparam logic [ADDR_W-1:0] ADR_TXSTAT = 4'h2;
    localparam logic [ADDR_W-1:0] ADR_RXSTAT = 4'h3;
    localparam logic [ADDR_W-1:0] ADR_CTRL   = 4'h4;
    localparam logic [1:0]        ADR_LAST_HI = 2'b10;

    localparam int GS_TX_EMPTY = 0;
    localparam int GS_TX_DONE  = 1;
    localparam int GS_RX_READY = 2;
    localparam int GS_RX_AVAIL = 3;
endpackage

// File: rtl/ewp_byte_fifo.sv
// Circular byte queue that can take and release up to LANES entries in one
// cycle. Assumes the caller never pushes more than the free space nor pops
// more than the fill level; flush empties it at the next edge.
module ewp_byte_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    parameter int LANES = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            flush,
    input  logic [$clog2(LANES+1)-1:0]      push_n,
    input  logic [LANES-1:0][W-1:0]         push_bytes,
    input  logic [$clog2(LANES+1)-1:0]      pop_n,
    output logic [LANES-1:0][W-1:0]         head,
    output logic [$clog2(DEPTH):0]          level
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] lvl;

    // Pointer and fill-level update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            lvl <= '0;
        end else begin
            wp  <= wp + AW'(push_n);
            rp  <= rp + AW'(pop_n);
            lvl <= lvl + CW'(push_n) - CW'(pop_n);
        end
    end

    // Storage write, one slot per pushed lane.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (i < int'(push_n) && !flush)
                mem[wp + AW'(i)] <= push_bytes[i];
        end
    end

    // Head window: the next LANES entries in queue order.
    always_comb begin
        for (int i = 0; i < LANES; i++)
            head[i] = mem[rp + AW'(i)];
    end

    assign level = lvl;
endmodule

// File: rtl/ewp_tx_side.sv
// Transmit path: splits host words into tagged bytes, queues them and
// offers them to the MAC one per cycle; holds the completion flag and the
// MAC's result code. Assumes body and last-word writes never coincide.
module ewp_tx_side #(
    parameter int DEPTH  = 64,
    parameter int STAT_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_body,
    input  logic                    wr_last,
    input  logic [1:0]              last_size,
    input  logic [31:0]             wdata,
    input  logic                    done_clr,
    input  logic                    mac_tx_ready,
    input  logic                    mac_tx_done,
    input  logic [STAT_W-1:0]       mac_tx_stat,
    output logic                    mac_tx_valid,
    output logic [7:0]              mac_tx_data,
    output logic                    mac_tx_last,
    output logic                    tx_empty,
    output logic                    done_flag,
    output logic [STAT_W-1:0]       stat_q,
    output logic [$clog2(DEPTH):0]  tx_level
);
    localparam int LANES = ewp_pkg::LANES;
    localparam int NW    = $clog2(LANES + 1);
    localparam int CW    = $clog2(DEPTH) + 1;

    logic [NW-1:0]           push_n, pop_n;
    logic [LANES-1:0][8:0]   push_bytes, head;
    logic                    room;

    assign room = tx_level <= CW'(DEPTH - LANES);

    // Number of bytes a host write contributes, zero when there is no room.
    always_comb begin
        push_n = '0;
        if (room) begin
            if (wr_body)
                push_n = NW'(LANES);
            else if (wr_last)
                push_n = (last_size == 2'd0) ? NW'(LANES) : NW'(last_size);
        end
    end

    // Lane split, low lane first, frame-end tag on the final pushed byte.
    always_comb begin
        for (int i = 0; i < LANES; i++)
            push_bytes[i] = {wr_last && (i == int'(push_n) - 1), wdata[8*i +: 8]};
    end

    assign pop_n = (mac_tx_valid && mac_tx_ready) ? NW'(1) : '0;

    ewp_byte_fifo #(.DEPTH(DEPTH), .W(9), .LANES(LANES)) u_q (
        .clk(clk), .rst_n(rst_n), .flush(1'b0),
        .push_n(push_n), .push_bytes(push_bytes),
        .pop_n(pop_n), .head(head), .level(tx_level)
    );

    assign mac_tx_valid = tx_level != '0;
    assign mac_tx_data  = head[0][7:0];
    assign mac_tx_last  = head[0][8];
    assign tx_empty     = tx_level == '0;

    // Completion flag (set wins over clear) and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_flag <= 1'b0;
            stat_q    <= '0;
        end else begin
            if (mac_tx_done) begin
                done_flag <= 1'b1;
                stat_q    <= mac_tx_stat;
            end else if (done_clr) begin
                done_flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ewp_rx_side.sv
// Receive path: queues MAC bytes, counts frame length, flags frame end and
// overrun, and packs up to four bytes per host read, earliest byte in the
// top lane. Assumes at most one MAC byte per cycle; disable acts as flush.
module ewp_rx_side #(
    parameter int DEPTH = 64,
    parameter int LEN_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_en,
    input  logic                    mac_rx_valid,
    input  logic [7:0]              mac_rx_data,
    input  logic                    mac_rx_last,
    input  logic                    host_pop,
    input  logic                    ready_clr,
    output logic [31:0]             rx_word,
    output logic                    rx_ready,
    output logic [LEN_W-1:0]        rx_len,
    output logic                    rx_overrun,
    output logic [$clog2(DEPTH):0]  rx_level
);
    localparam int LANES = ewp_pkg::LANES;
    localparam int NW    = $clog2(LANES + 1);
    localparam int CW    = $clog2(DEPTH) + 1;

    logic [NW-1:0]           push_n, pop_n, avail;
    logic [LANES-1:0][7:0]   push_bytes, head;
    logic                    full, take;
    logic [LEN_W-1:0]        cnt;

    assign full  = rx_level == CW'(DEPTH);
    assign take  = rx_en && mac_rx_valid;
    assign push_n = (take && !full) ? NW'(1) : '0;
    assign avail = (rx_level >= CW'(LANES)) ? NW'(LANES) : rx_level[NW-1:0];
    assign pop_n = host_pop ? avail : '0;

    // Incoming byte always presented on lane 0.
    always_comb begin
        push_bytes    = '0;
        push_bytes[0] = mac_rx_data;
    end

    ewp_byte_fifo #(.DEPTH(DEPTH), .W(8), .LANES(LANES)) u_q (
        .clk(clk), .rst_n(rst_n), .flush(!rx_en),
        .push_n(push_n), .push_bytes(push_bytes),
        .pop_n(pop_n), .head(head), .level(rx_level)
    );

    // Word packing: earliest byte to bits 31:24, absent lanes zero.
    always_comb begin
        rx_word = '0;
        for (int k = 0; k < LANES; k++)
            if (k < int'(avail))
                rx_word[31 - 8*k -: 8] = head[k];
    end

    // Frame length counter, length capture and sticky overrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            rx_len     <= '0;
            rx_overrun <= 1'b0;
        end else if (!rx_en) begin
            cnt        <= '0;
            rx_overrun <= 1'b0;
        end else if (mac_rx_valid) begin
            if (full)
                rx_overrun <= 1'b1;
            if (mac_rx_last) begin
                rx_len <= cnt + LEN_W'(1);
                cnt    <= '0;
            end else begin
                cnt    <= cnt + LEN_W'(1);
            end
        end
    end

    // Frame-ready flag, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_ready <= 1'b0;
        else if (take && mac_rx_last)
            rx_ready <= 1'b1;
        else if (ready_clr)
            rx_ready <= 1'b0;
    end
endmodule

// File: rtl/eth_word_port.sv
// Top of the host FIFO word interface: decodes the register port, holds the
// receive-enable control bit and returns registered read data. Assumes
// reg_rd and reg_wr strobes last one cycle per access.
module eth_word_port #(
    parameter int TX_DEPTH = 64,
    parameter int RX_DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    input  logic        reg_rd,
    output logic [31:0] reg_rdata,
    output logic        mac_tx_valid,
    output logic [7:0]  mac_tx_data,
    output logic        mac_tx_last,
    input  logic        mac_tx_ready,
    input  logic        mac_tx_done,
    input  logic [11:0] mac_tx_stat,
    input  logic        mac_rx_valid,
    input  logic [7:0]  mac_rx_data,
    input  logic        mac_rx_last
);
    import ewp_pkg::*;

    localparam int TCW = $clog2(TX_DEPTH) + 1;
    localparam int RCW = $clog2(RX_DEPTH) + 1;

    logic              is_last, wr_body, wr_last, done_clr, ready_clr, host_pop;
    logic              rx_en_q, tx_empty, tx_done_q, rx_rdy_q, rx_ovr;
    logic [STAT_W-1:0] tx_stat;
    logic [LEN_W-1:0]  rx_len;
    logic [31:0]       rx_word, gstat, rd_mux;
    logic [TCW-1:0]    tx_lvl;
    logic [RCW-1:0]    rx_lvl;
    logic [3:0]        part;

    assign is_last   = reg_addr[3:2] == ADR_LAST_HI;
    assign wr_body   = reg_wr && reg_addr == ADR_DATA;
    assign wr_last   = reg_wr && is_last;
    assign done_clr  = reg_wr && reg_addr == ADR_GSTAT && reg_wdata[GS_TX_DONE];
    assign ready_clr = reg_wr && reg_addr == ADR_GSTAT && reg_wdata[GS_RX_READY];
    assign host_pop  = reg_rd && reg_addr == ADR_DATA;

    ewp_tx_side #(.DEPTH(TX_DEPTH), .STAT_W(STAT_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .wr_body(wr_body), .wr_last(wr_last), .last_size(reg_addr[1:0]),
        .wdata(reg_wdata), .done_clr(done_clr),
        .mac_tx_ready(mac_tx_ready), .mac_tx_done(mac_tx_done),
        .mac_tx_stat(mac_tx_stat),
        .mac_tx_valid(mac_tx_valid), .mac_tx_data(mac_tx_data),
        .mac_tx_last(mac_tx_last), .tx_empty(tx_empty),
        .done_flag(tx_done_q), .stat_q(tx_stat), .tx_level(tx_lvl)
    );

    ewp_rx_side #(.DEPTH(RX_DEPTH), .LEN_W(LEN_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en_q),
        .mac_rx_valid(mac_rx_valid), .mac_rx_data(mac_rx_data),
        .mac_rx_last(mac_rx_last), .host_pop(host_pop),
        .ready_clr(ready_clr), .rx_word(rx_word), .rx_ready(rx_rdy_q),
        .rx_len(rx_len), .rx_overrun(rx_ovr), .rx_level(rx_lvl)
    );

    // Receive-enable control bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_en_q <= 1'b0;
        else if (reg_wr && reg_addr == ADR_CTRL)
            rx_en_q <= reg_wdata[0];
    end

    assign part = (rx_lvl != '0 && rx_lvl < RCW'(LANES)) ? 4'(rx_lvl) : 4'd0;

    // General status word assembly.
    always_comb begin
        gstat = '0;
        gstat[31:28]       = part;
        gstat[GS_TX_EMPTY] = tx_empty;
        gstat[GS_TX_DONE]  = tx_done_q;
        gstat[GS_RX_READY] = rx_rdy_q;
        gstat[GS_RX_AVAIL] = rx_lvl != '0;
    end

    // Read multiplexer.
    always_comb begin
        case (reg_addr)
            ADR_DATA:   rd_mux = rx_word;
            ADR_GSTAT:  rd_mux = gstat;
            ADR_TXSTAT: rd_mux = {{(32-STAT_W){1'b0}}, tx_stat};
            ADR_RXSTAT: rd_mux = {rx_len, 15'd0, rx_ovr};
            ADR_CTRL:   rd_mux = {31'd0, rx_en_q};
            default:    rd_mux = '0;
        endcase
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_rd)
            reg_rdata <= rd_mux;
    end
endmodule

// File: rtl/ewp_checker.sv
// Property checker for eth_word_port, attached by bind below.
module ewp_checker #(
    parameter int TX_DEPTH = 64,
    parameter int RX_DEPTH = 64
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [3:0]                  reg_addr,
    input logic                        reg_rd,
    input logic [31:0]                 reg_rdata,
    input logic                        mac_tx_valid,
    input logic                        mac_tx_ready,
    input logic [7:0]                  mac_tx_data,
    input logic                        mac_tx_last,
    input logic                        mac_tx_done,
    input logic                        mac_rx_valid,
    input logic                        mac_rx_last,
    input logic                        rx_en,
    input logic [$clog2(TX_DEPTH):0]   tx_level,
    input logic [$clog2(RX_DEPTH):0]   rx_level,
    input logic                        tx_done_flag,
    input logic                        rx_ready_flag
);
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mac_tx_valid && !mac_tx_ready |=> mac_tx_valid && $stable(mac_tx_data) && $stable(mac_tx_last)); // R11

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && reg_addr == 4'h0 && rx_level == '0 |=> reg_rdata == 32'd0); // R9

    AST_EMPTY_READ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && reg_addr == 4'h0 && rx_level == '0 && !mac_rx_valid |=> rx_level == '0); // R9

    AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        mac_tx_done |=> tx_done_flag); // R5

    AST_READY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en && mac_rx_valid && mac_rx_last |=> rx_ready_flag); // R6

    AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> rx_level == '0); // R10

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tx_level) <= TX_DEPTH && int'(rx_level) <= RX_DEPTH); // R4
endmodule

bind eth_word_port ewp_checker #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .mac_tx_valid(mac_tx_valid),
    .mac_tx_ready(mac_tx_ready), .mac_tx_data(mac_tx_data),
    .mac_tx_last(mac_tx_last), .mac_tx_done(mac_tx_done),
    .mac_rx_valid(mac_rx_valid), .mac_rx_last(mac_rx_last),
    .rx_en(rx_en_q), .tx_level(tx_lvl), .rx_level(rx_lvl),
    .tx_done_flag(tx_done_q), .rx_ready_flag(rx_rdy_q)
);

// File: tb/eth_word_port_test.sv
`timescale 1ns/1ps
module eth_word_port_test;
    logic        clk = 0, rst_n = 0;
    logic [3:0]  reg_addr = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        mac_tx_valid, mac_tx_last;
    logic [7:0]  mac_tx_data;
    logic        mac_tx_ready = 0, mac_tx_done = 0;
    logic [11:0] mac_tx_stat = 0;
    logic        mac_rx_valid = 0, mac_rx_last = 0;
    logic [7:0]  mac_rx_data = 0;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [7:0] fb [0:127];
    logic [7:0] got [0:255];
    logic       gotl [0:255];

    eth_word_port uut (.*);

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1;
        @(negedge clk); reg_rd = 0; d = reg_rdata;
    endtask

    task automatic drain(output int n);
        n = 0;
        @(negedge clk); mac_tx_ready = 1;
        while (mac_tx_valid && n < 250) begin
            got[n] = mac_tx_data; gotl[n] = mac_tx_last; n++;
            @(negedge clk);
        end
        mac_tx_ready = 0;
    endtask

    task automatic rx_send(input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            mac_rx_valid = 1; mac_rx_data = fb[i]; mac_rx_last = (i == len - 1);
        end
        @(negedge clk); mac_rx_valid = 0; mac_rx_last = 0;
    endtask

    function automatic logic [31:0] pack_rx(input int w, input int len);
        logic [31:0] r = 0;
        for (int k = 0; k < 4; k++)
            if (4*w + k < len) r[31-8*k -: 8] = fb[4*w + k];
        return r;
    endfunction

    function automatic logic [31:0] pack_tx(input int w);
        return {fb[4*w+3], fb[4*w+2], fb[4*w+1], fb[4*w]};
    endfunction

    // Writes a frame of len bytes from fb via body words plus a last word.
    task automatic tx_frame(input int len);
        int nw, rem;
        nw  = (len - 1) / 4;
        rem = len - 4*nw;
        for (int w = 0; w < nw; w++) wr(4'h0, pack_tx(w));
        wr(4'h8 | 4'(rem & 3), pack_tx(nw));
    endtask

    task automatic rx_check(input int len, input string tag);
        logic [31:0] d;
        int nwd;
        nwd = (len + 3) / 4;
        rd(4'h3, d); chk({tag, " R6 length"}, d, {16'(len), 16'h0});
        for (int w = 0; w < nwd; w++) begin
            if (w == nwd - 1 && (len % 4) != 0) begin
                rd(4'h1, d); chk({tag, " R8 tail count"}, {28'd0, d[31:28]}, 32'(len % 4));
            end
            rd(4'h0, d); chk({tag, " R7 word"}, d, pack_rx(w, len));
        end
        rd(4'h1, d); chk({tag, " R7 avail clear"}, {31'd0, d[3]}, 0);
        wr(4'h1, 32'h4);
        rd(4'h1, d); chk({tag, " R6 ready cleared"}, {31'd0, d[2]}, 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int n, len;
        int unsigned seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(4'h1, d); chk("R1 gstat", d, 32'h1);
        rd(4'h4, d); chk("R1 ctrl", d, 0);
        rd(4'h2, d); chk("R1 txstat", d, 0);
        rd(4'h3, d); chk("R1 rxstat", d, 0);
        chk("R1 tx valid", {31'd0, mac_tx_valid}, 0);

        // R2/R3 directed: one body word plus a two-byte tail
        wr(4'h0, 32'h44332211);
        wr(4'hA, 32'hEEFF6655);
        rd(4'h1, d); chk("R2 tx not empty", {31'd0, d[0]}, 0);
        drain(n);
        chk("R3 byte count", n, 6);
        for (int i = 0; i < 6; i++) begin
            chk("R2 byte order", got[i], 8'h11 * (i + 1));
            chk("R3 last flag", {31'd0, gotl[i]}, {31'd0, i == 5});
        end
        rd(4'h1, d); chk("R2 tx empty again", {31'd0, d[0]}, 1);

        // R4/R11 overflow with MAC stalled
        for (int w = 0; w < 17; w++)
            wr(4'h0, {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)});
        wr(4'h9, 32'hFF);
        @(negedge clk); d = {23'd0, mac_tx_valid, mac_tx_data};
        @(negedge clk); chk("R11 hold", {23'd0, mac_tx_valid, mac_tx_data}, d);
        drain(n);
        chk("R4 capacity", n, 64);
        for (int i = 0; i < 64; i++) begin
            chk("R4 content", got[i], 8'(i));
            chk("R4 no last", {31'd0, gotl[i]}, 0);
        end

        // R5 completion flag
        @(negedge clk); mac_tx_done = 1; mac_tx_stat = 12'hA5C;
        @(negedge clk); mac_tx_done = 0; mac_tx_stat = 0;
        rd(4'h1, d); chk("R5 done set", {31'd0, d[1]}, 1);
        rd(4'h2, d); chk("R5 status", d, 32'hA5C);
        wr(4'h1, 32'h0);
        rd(4'h1, d); chk("R5 write zero keeps", {31'd0, d[1]}, 1);
        wr(4'h1, 32'h2);
        rd(4'h1, d); chk("R5 w1c", {31'd0, d[1]}, 0);

        // R2/R3 random transmit frames
        for (int f = 0; f < 8; f++) begin
            len = (f < 4) ? 4 + f : 1 + int'($urandom % 40);
            for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
            tx_frame(len);
            drain(n);
            chk("R3 random length", n, len);
            for (int i = 0; i < len && i < n; i++) begin
                chk("R2 random byte", got[i], fb[i]);
                chk("R3 random last", {31'd0, gotl[i]}, {31'd0, i == len - 1});
            end
        end

        // R9 empty read
        wr(4'h4, 32'h1);
        rd(4'h0, d); chk("R9 empty read zero", d, 0);
        rd(4'h1, d); chk("R9 still empty", {28'd0, d[3:0]} & 32'h8, 0);

        // R6/R7/R8 directed seven-byte frame
        for (int i = 0; i < 7; i++) fb[i] = 8'(i + 1);
        rx_send(7);
        rd(4'h1, d);
        chk("R6 ready", {31'd0, d[2]}, 1);
        chk("R8 full words zero field", {28'd0, d[31:28]}, 0);
        chk("R7 avail", {31'd0, d[3]}, 1);
        rx_check(7, "dir");

        // R6/R7/R8 random receive frames
        for (int f = 0; f < 8; f++) begin
            len = 1 + int'($urandom % 40);
            for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
            rx_send(len);
            rx_check(len, "rnd");
        end

        // R10 overrun, flush and disabled input
        for (int i = 0; i < 66; i++) fb[i] = 8'(i + 100);
        rx_send(66);
        rd(4'h3, d); chk("R10 overrun length", d, {16'd66, 16'h1});
        wr(4'h1, 32'h4);
        wr(4'h4, 32'h0);
        rd(4'h1, d); chk("R10 flushed", {31'd0, d[3]}, 0);
        rd(4'h3, d); chk("R10 overrun cleared", d, {16'd66, 16'h0});
        rd(4'h0, d); chk("R9 read after flush", d, 0);
        fb[0] = 8'h5A;
        rx_send(1);
        rd(4'h1, d); chk("R10 disabled ignored", {29'd0, d[3:2], 1'b0}, 0);
        wr(4'h4, 32'h1);
        fb[0] = 8'hAB; fb[1] = 8'hCD;
        rx_send(2);
        rd(4'h0, d); chk("R10 fresh data", d, 32'hABCD0000);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule